// File: doc/BRIEF.md
# Leading-One Natural Logarithm Unit

This block returns an approximate natural logarithm of a positive unsigned fixed-point operand. The binary point of the operand is a parameter. A priority scan finds the most significant set bit. Its distance from the binary point is the base-2 exponent, which goes negative for operands below one. A left shift then aligns the bits beneath that leading one into a fraction field.

Because log2 of a mantissa in [1,2) is approximated by the mantissa minus one, the base-2 logarithm is simply the exponent placed above the fraction field. No adder is needed for it. That value is then scaled by eleven sixteenths (binary 0.1011), which stands in for ln 2. The scaling is done by a three-operand carry-save reduction followed by a single carry-propagate add.

The result is registered one cycle after the operand is presented. A zero operand raises a flag and forces the most negative output code.

Top module: `lead_one_ln`

## Requirements
- R1: When `in_valid` is high on a rising clock edge, `out_valid` is high after that edge; otherwise `out_valid` is low after it. There is exactly one cycle of latency, and a new operand may be accepted every cycle.
- R2: For a non-zero operand, the exponent w is the bit index of the highest set bit of `in_f` minus `IN_FRAC`. With the defaults (8 bits, 3 fraction bits), w spans -3 to 4.
- R3: The base-2 logarithm L is a signed fixed-point value with FW = `IN_W`-1 fraction bits. Its integer part is w in two's complement. Its fraction field holds the bits below the leading one, shifted left so that the bit just beneath the leading one sits in the fraction MSB, with zeros filled below.
- R4: `out_ln` equals 11·L exactly as a signed integer, and carries FW+4 fraction bits. With the defaults, `out_ln` is 15 bits wide with 11 fraction bits.
- R5: For non-zero operands below 1.0 (below 2^`IN_FRAC`), the sign bit of `out_ln` is 1. For operands of 1.0 or above, it is 0. An operand of exactly 1.0 gives zero.
- R6: A zero operand accepted with `in_valid` sets `out_invalid` and sets `out_ln` to the most negative code: a 1 in the MSB and zeros elsewhere. The next non-zero operand clears the flag.
- R7: While `rst_n` is low at a clock edge, `out_valid`, `out_invalid` and `out_ln` all become 0.
- R8: An edge with `in_valid` low leaves `out_ln` and `out_invalid` unchanged, whatever `in_f` holds.
- R9: With the defaults, the following operands give these exponents and fraction fields:
  - 11011.111 gives w = 4 and fraction 1011111.
  - 01010.101 gives w = 3.
  - 00001.101 gives w = 0.
  - 00000.011 gives w = -2 and fraction 1000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand qualifier |
| in_f | input | IN_W | Unsigned operand with IN_FRAC fraction bits |
| out_valid | output | 1 | Result qualifier, one cycle after in_valid |
| out_ln | output | W+IN_W+3 (15 by default) | Signed ln approximation with IN_W+3 fraction bits |
| out_invalid | output | 1 | Operand was zero |

## Verification
The bench builds the block with its defaults: an 8-bit operand with three fraction bits. These settings put every exponent from -3 to 4 within reach, including the negative exponents that need a left shift past the binary point. Since there are only 255 non-zero codes, the bench applies every one of them against a model written from the requirements, alongside the four worked operands. This covers every leading-one position, every fraction pattern and the sign change at 1.0. Directed steps cover back-to-back issue, idle cycles with a changing operand, and the zero operand followed by recovery.

// File: rtl/lnu_pkg.sv
// Package: width helpers shared by the natural-log unit.
// Assumes in_w >= 2 and 0 <= in_frac < in_w.
package lnu_pkg;

    // Guard bits added by the x11 scaling (11 < 16).
    localparam int LN2_GUARD = 4;

    // Width of the normalised fraction field.
    function automatic int frac_w(input int in_w);
        return in_w - 1;
    endfunction

    // Signed width that holds every exponent from -in_frac to in_w-1-in_frac.
    function automatic int exp_w(input int in_w, input int in_frac);
        int mx;
        mx = (in_frac > in_w - 1 - in_frac) ? in_frac : in_w - 1 - in_frac;
        return $clog2(mx + 1) + 1;
    endfunction

    // Width of the base-2 log value: exponent above fraction.
    function automatic int log_w(input int in_w, input int in_frac);
        return exp_w(in_w, in_frac) + frac_w(in_w);
    endfunction

    // Width of the scaled output.
    function automatic int out_w(input int in_w, input int in_frac);
        return log_w(in_w, in_frac) + LN2_GUARD;
    endfunction

endpackage

// File: rtl/lnu_lod.sv
// Leading-one detector: reports the bit index of the highest set bit.
// Assumes nothing about the operand; a zero operand returns index 0 with
// is_zero raised, and the caller decides what that means.
module lnu_lod #(
    parameter int IN_W  = 8,
    parameter int POS_W = $clog2(IN_W)
) (
    input  logic [IN_W-1:0]  f,
    output logic [POS_W-1:0] pos,
    output logic             is_zero
);

    // Upward scan; the last set bit seen is the highest one.
    always_comb begin
        pos = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (f[i]) pos = POS_W'(i);
        end
    end

    // Zero detect, kept separate from the scan.
    always_comb is_zero = (f == '0);

endmodule

// File: rtl/lnu_norm.sv
// Normaliser: turns the leading-one index into the signed exponent and
// left-aligns the bits below the leading one into the fraction field.
// Assumes pos is the true leading-one index of f (f non-zero).
module lnu_norm #(
    parameter int IN_W    = 8,
    parameter int IN_FRAC = 3,
    parameter int POS_W   = $clog2(IN_W),
    parameter int W_W     = lnu_pkg::exp_w(IN_W, IN_FRAC),
    parameter int FW      = lnu_pkg::frac_w(IN_W)
) (
    input  logic [IN_W-1:0]       f,
    input  logic [POS_W-1:0]      pos,
    output logic signed [W_W-1:0] w,
    output logic [FW-1:0]         frac
);

    logic [POS_W-1:0] sh;

    // Exponent: leading-one index measured from the binary point.
    always_comb w = W_W'(int'(pos) - IN_FRAC);

    // Shift distance that pushes the leading one just above the field.
    always_comb sh = POS_W'(IN_W - 1) - pos;

    // Fraction field: shifted operand with the leading one dropped off the top.
    always_comb frac = FW'(f << sh);

endmodule

// File: rtl/lnu_csa_ln2.sv
// Constant scaler by binary 0.1011 (ln 2 approximation), written as x11.
// The three terms x8, x2 and x1 pass through one carry-save row and one
// final add. The output is the integer 11*l; the caller attaches the four
// extra fraction bits. Assumes P_W >= L_W+4 so the product cannot wrap.
module lnu_csa_ln2 #(
    parameter int L_W = 11,
    parameter int P_W = L_W + lnu_pkg::LN2_GUARD
) (
    input  logic signed [L_W-1:0] l,
    output logic signed [P_W-1:0] p
);

    logic [P_W-1:0] ext, t_a, t_b, t_c;
    logic [P_W-1:0] s_row, c_row;

    // Sign-extend and form the three shifted terms.
    always_comb begin
        ext = P_W'(l);
        t_a = ext << 3;
        t_b = ext << 1;
        t_c = ext;
    end

    // One full adder per bit: the carry-save row.
    for (genvar i = 0; i < P_W; i++) begin : g_csa
        assign s_row[i] = t_a[i] ^ t_b[i] ^ t_c[i];
        assign c_row[i] = (t_a[i] & t_b[i]) | (t_a[i] & t_c[i]) | (t_b[i] & t_c[i]);
    end

    // Carry-propagate merge of sum and shifted carry rows.
    always_comb p = $signed(s_row + {c_row[P_W-2:0], 1'b0});

endmodule

// File: rtl/lead_one_ln.sv
// Natural-log unit: ln F ~ 0.1011b * (w + (k - 1)), where F = 2^w * k.
// Single registered stage; accepts one operand per cycle. Assumes the
// operand is unsigned with IN_FRAC fraction bits. A zero operand is
// flagged and yields the most negative output code.
module lead_one_ln #(
    parameter int IN_W    = 8,
    parameter int IN_FRAC = 3
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           in_valid,
    input  logic [IN_W-1:0]                                in_f,
    output logic                                           out_valid,
    output logic [lnu_pkg::out_w(IN_W, IN_FRAC)-1:0]       out_ln,
    output logic                                           out_invalid
);

    localparam int POS_W = $clog2(IN_W);
    localparam int W_W   = lnu_pkg::exp_w(IN_W, IN_FRAC);
    localparam int FW    = lnu_pkg::frac_w(IN_W);
    localparam int L_W   = lnu_pkg::log_w(IN_W, IN_FRAC);
    localparam int O_W   = lnu_pkg::out_w(IN_W, IN_FRAC);
    localparam logic [O_W-1:0]  OUT_MIN = {1'b1, {(O_W-1){1'b0}}};
    localparam logic [IN_W-1:0] F_ONE   = IN_W'(1) << IN_FRAC;

    logic [POS_W-1:0]      lod_pos;
    logic                  lod_zero;
    logic signed [W_W-1:0] exp_w;
    logic [FW-1:0]         frac_k;
    logic signed [L_W-1:0] log2_val;
    logic signed [O_W-1:0] ln_val;

    lnu_lod #(.IN_W(IN_W), .POS_W(POS_W)) u_lod (
        .f       (in_f),
        .pos     (lod_pos),
        .is_zero (lod_zero)
    );

    // R2: the reported index must hold a one with nothing set above it.
    a_r2_lead_one: assert property (@(posedge clk) disable iff (!rst_n)
        (in_f != '0) |-> (in_f[lod_pos] && ((in_f >> lod_pos) == IN_W'(1))));

    lnu_norm #(.IN_W(IN_W), .IN_FRAC(IN_FRAC), .POS_W(POS_W), .W_W(W_W), .FW(FW)) u_norm (
        .f    (in_f),
        .pos  (lod_pos),
        .w    (exp_w),
        .frac (frac_k)
    );

    // Base-2 log: exponent above fraction, no adder (log2 k ~ k - 1).
    always_comb log2_val = {exp_w, frac_k};

    lnu_csa_ln2 #(.L_W(L_W), .P_W(O_W)) u_scale (
        .l (log2_val),
        .p (ln_val)
    );

    // Output stage: qualifier every cycle, data and flag only on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_invalid <= 1'b0;
            out_ln      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_invalid <= lod_zero;
                out_ln      <= lod_zero ? OUT_MIN : ln_val;
            end
        end
    end

    // R1: the qualifier follows the input qualifier by one edge.
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R6: a zero operand is flagged and clamps to the most negative code.
    a_r6_zero_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_f == '0) |=> (out_invalid && out_ln == OUT_MIN));

    // R5: operands below one give a negative log.
    a_r5_neg_below_one: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_f != '0 && in_f < F_ONE) |=> out_ln[O_W-1]);

    // R5: operands of one or more give a non-negative log.
    a_r5_pos_from_one: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_f >= F_ONE) |=> (!out_ln[O_W-1] && !out_invalid));

    // R8: idle edges leave the result untouched.
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_ln) && $stable(out_invalid)));

endmodule

// File: tb/lead_one_ln_tb.sv
`timescale 1ns/1ps
module lead_one_ln_tb;

    localparam int IN_W    = 8;
    localparam int IN_FRAC = 3;
    localparam int O_W     = 15;
    localparam int NV      = 12;

    // Operand and expected base-2 log L (7 fraction bits), worked by hand.
    localparam logic [7:0] VEC_F [NV] = '{8'hDF, 8'h55, 8'h0D, 8'h03, 8'h08, 8'h01,
                                          8'hFF, 8'h80, 8'h10, 8'h04, 8'h07, 8'h33};
    localparam int         VEC_L [NV] = '{607, 426, 80, -192, 0, -384,
                                          639, 512, 128, -128, -32, 332};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [IN_W-1:0] in_f = '0;
    logic            out_valid;
    logic [O_W-1:0]  out_ln;
    logic            out_invalid;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    lead_one_ln #(.IN_W(IN_W), .IN_FRAC(IN_FRAC)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_f        (in_f),
        .out_valid   (out_valid),
        .out_ln      (out_ln),
        .out_invalid (out_invalid)
    );

    // Model from R2/R3: L = w*2^7 + left-aligned bits below the leading one.
    function automatic int model_l(input logic [7:0] f);
        int msb = 0;
        int fr;
        for (int i = 0; i < 8; i++) if (f[i]) msb = i;
        fr = (int'(f) << (7 - msb)) & 127;
        return (msb - IN_FRAC) * 128 + fr;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] f);
        @(negedge clk);
        in_valid = 1'b1;
        in_f     = f;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic int ln_s();
        return int'($signed(out_ln));
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int held;
        // R7: reset state
        repeat (3) @(negedge clk);
        check("R7 out_valid", int'(out_valid), 0);
        check("R7 out_invalid", int'(out_invalid), 0);
        check("R7 out_ln", ln_s(), 0);
        rst_n = 1'b1;

        // R9/R4/R1: table of worked operands
        for (int v = 0; v < NV; v++) begin
            apply(VEC_F[v]);
            check("R1 out_valid", int'(out_valid), 1);
            check("R9 R4 out_ln", ln_s(), 11 * VEC_L[v]);
            check("R6 out_invalid low", int'(out_invalid), 0);
        end

        // R8: idle cycles with a changing operand keep the result
        held = ln_s();
        @(negedge clk);
        in_f = 8'h55;
        check("R1 out_valid idle", int'(out_valid), 0);
        @(negedge clk);
        in_f = 8'h00;
        @(negedge clk);
        check("R8 out_ln held", ln_s(), held);
        check("R8 out_invalid held", int'(out_invalid), 0);

        // R6: zero operand, then recovery
        apply(8'h00);
        check("R6 out_invalid", int'(out_invalid), 1);
        check("R6 out_ln min", ln_s(), -16384);
        @(negedge clk);
        in_f = 8'h20;
        @(negedge clk);
        check("R8 flag held", int'(out_invalid), 1);
        check("R8 min held", ln_s(), -16384);
        apply(8'h08);
        check("R6 flag cleared", int'(out_invalid), 0);
        check("R5 one gives zero", ln_s(), 0);

        // R1: back-to-back issue, one result per cycle
        @(negedge clk);
        in_valid = 1'b1;
        in_f     = 8'hDF;
        for (int v = 1; v < 4; v++) begin
            @(negedge clk);
            check("R1 stream valid", int'(out_valid), 1);
            check("R1 stream data", ln_s(), 11 * model_l(VEC_F[v - 1]));
            in_f = VEC_F[v];
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 stream last", ln_s(), 11 * model_l(VEC_F[3]));

        // R2/R3/R4/R5: every non-zero operand
        for (int f = 1; f < 256; f++) begin
            apply(8'(f));
            check("R3 R4 sweep", ln_s(), 11 * model_l(8'(f)));
            check("R5 sign", int'(out_ln[O_W-1]), (f < 8) ? 1 : 0);
        end

        finish_run();
    end

endmodule